// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block sits at the writeback end of an in-order five-stage pipeline. It decides whether the instruction in writeback retires or faults. Each stage reports a valid bit. The writeback stage also reports an exception flag, a 4-bit cause, the instruction address, a flag marking a branch delay slot, its register-write enable and, for stores, its store-queue slot. A fault is resolved only at writeback, so every older instruction has already retired. In the same cycle the controller strips the valid bit from the faulting instruction and from every younger one, suppresses the register write and cancels the matching store-queue entry. It then records the restart address and the cause.

A software-handled fault steers fetch to a fixed handler address and raises an exception-level flag. A return input ends that mode and resumes at the recorded address. A cache-miss cause uses the same flush path but does not enter the handler. The controller waits for a refill-complete pulse, holds every stage invalid in the meantime, and then restarts the missed instruction. A small checker on the execute-stage adder gives the wrapping sum and flags signed overflow for trapping adds, so that the pipeline can raise the overflow cause.

Top module: `excp_commit_ctrl`

## Requirements
- R1: After reset `exl_o`, `refill_wait_o`, `redirect_o`, `epc_o` and `cause_o` are all zero.
- R2: `ex_sum_o` is always `ex_a_i + ex_b_i` modulo 2^32. `ex_ovf_o` is 1 only when `ex_trap_add_i` is 1 and both operands have the same sign bit while the sum's sign bit differs from it.
- R3: An exception is taken when `stg_vld_i[4]` (writeback; bit 0 is fetch) and `wb_exc_i` are both 1 while neither `exl_o` nor `refill_wait_o` is set. In that same cycle `stg_vld_o` is all zero. With no exception taken, `stg_vld_o` equals `stg_vld_i`.
- R4: `rf_we_o` is 0 in a cycle that takes an exception. Otherwise it equals `stg_vld_o[4] & wb_rf_we_i`.
- R5: When a faulting store is taken, `sq_cancel_o` is 1, `sq_commit_o` is 0 and `sq_idx_o` equals `wb_sq_idx_i`. A valid store that is not faulting gives `sq_commit_o` = 1 and `sq_cancel_o` = 0. The two outputs are never 1 together.
- R6: A taken exception whose cause is not 3 drives `redirect_o` = 1 with `redirect_pc_o` = 0x180 in that cycle. `exl_o` is 1 from the next cycle on.
- R7: In the cycle after a take, `cause_o` holds `wb_cause_i` (1 overflow, 2 TLB miss, 3 cache-miss restart) and `epc_o` holds `wb_pc_i`, or `wb_pc_i - 4` when `wb_dslot_i` was 1.
- R8: While `exl_o` is 1, a faulting writeback instruction is ignored: no redirect, `stg_vld_o` equals `stg_vld_i`, and `epc_o` and `cause_o` keep their values.
- R9: `eret_i` with `exl_o` = 1 drives `redirect_o` = 1 with `redirect_pc_o` = `epc_o`, and `exl_o` clears on the next cycle. `eret_i` with `exl_o` = 0 has no effect.
- R10: A taken exception with cause 3 drives no redirect and sets `refill_wait_o` on the next cycle. While `refill_wait_o` is 1, `stg_vld_o` and `rf_we_o` are 0 and faulting instructions are ignored.
- R11: `refill_done_i` while `refill_wait_o` is 1 drives `redirect_o` = 1 with `redirect_pc_o` = `epc_o`, and `refill_wait_o` clears on the next cycle. `refill_done_i` at other times has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stg_vld_i | input | 5 | Stage valid bits, bit 4 writeback, bit 0 fetch |
| wb_exc_i | input | 1 | Writeback instruction carries an exception |
| wb_cause_i | input | 4 | Cause code of the writeback instruction |
| wb_pc_i | input | 32 | Address of the writeback instruction |
| wb_dslot_i | input | 1 | Writeback instruction sits in a branch delay slot |
| wb_rf_we_i | input | 1 | Writeback instruction wants a register write |
| wb_store_i | input | 1 | Writeback instruction is a store |
| wb_sq_idx_i | input | 3 | Store-queue slot of the writeback store |
| ex_a_i | input | 32 | Execute adder operand A |
| ex_b_i | input | 32 | Execute adder operand B |
| ex_trap_add_i | input | 1 | Execute add is the trapping form |
| eret_i | input | 1 | Handler return |
| refill_done_i | input | 1 | Cache refill finished |
| ex_sum_o | output | 32 | Wrapping sum |
| ex_ovf_o | output | 1 | Trapping add overflowed |
| stg_vld_o | output | 5 | Stage valid bits after flush |
| rf_we_o | output | 1 | Register write permitted |
| sq_commit_o | output | 1 | Store-queue entry may drain |
| sq_cancel_o | output | 1 | Store-queue entry cancelled |
| sq_idx_o | output | 3 | Slot for commit or cancel |
| redirect_o | output | 1 | Fetch redirect this cycle |
| redirect_pc_o | output | 32 | Redirect target |
| epc_o | output | 32 | Recorded restart address |
| cause_o | output | 4 | Recorded cause |
| exl_o | output | 1 | Exception level active |
| refill_wait_o | output | 1 | Waiting for cache refill |

## Verification
Flush, write suppression, store cancel and redirect are all combinational from the take condition. A wrong mode register therefore shows in the same cycle as a missing or spurious redirect, or as valid bits that pass through when they should be cleared. A wrong restart address or cause capture shows one cycle after the take on `epc_o` and `cause_o`. It then shows again when the return or the refill-done pulse redirects to that stored address. A mode that fails to ignore a second fault shows as a changed `epc_o` one cycle after the ignored fault.

// File: rtl/excp_pkg.sv
package excp_pkg;
  localparam int CAUSE_W = 4;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE = 4'd0,
    CAUSE_OVF  = 4'd1,
    CAUSE_TLB  = 4'd2,
    CAUSE_MISS = 4'd3
  } cause_e;

  typedef enum logic [1:0] {
    MODE_RUN    = 2'd0,
    MODE_EXL    = 2'd1,
    MODE_REFILL = 2'd2
  } mode_e;
endpackage

// File: rtl/excp_add_ovf.sv
module excp_add_ovf #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            trap_i,
  output logic [XLEN-1:0] sum_o,
  output logic            ovf_o
);
  localparam int MSB = XLEN - 1;

  logic same_sign;
  logic sign_flip;

  always_comb begin
    sum_o     = a_i + b_i;
    same_sign = (a_i[MSB] == b_i[MSB]);
    sign_flip = (sum_o[MSB] != a_i[MSB]);
    ovf_o     = trap_i & same_sign & sign_flip;
  end
endmodule

// File: rtl/excp_restart_pc.sv
module excp_restart_pc #(
  parameter int XLEN        = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic            dslot_i,
  output logic [XLEN-1:0] restart_pc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

  // a slot instruction restarts at its branch
  always_comb restart_pc_o = dslot_i ? (pc_i - STEP) : pc_i;
endmodule

// File: rtl/excp_flush_gen.sv
module excp_flush_gen #(
  parameter int NSTG = 5
) (
  input  logic [NSTG-1:0] vld_i,
  input  logic            kill_i,
  output logic [NSTG-1:0] vld_o
);
  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    assign vld_o[s] = vld_i[s] & ~kill_i;
  end
endmodule

// File: rtl/excp_mode_fsm.sv
module excp_mode_fsm
  import excp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               take_i,
  input  logic               miss_i,
  input  logic               eret_i,
  input  logic               refill_done_i,
  input  logic [XLEN-1:0]    restart_pc_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output mode_e              mode_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [CAUSE_W-1:0] cause_o
);
  mode_e              mode_q;
  logic [XLEN-1:0]    epc_q;
  logic [CAUSE_W-1:0] cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_RUN;
      epc_q   <= '0;
      cause_q <= '0;
    end else begin
      unique case (mode_q)
        MODE_RUN: if (take_i) begin
          epc_q   <= restart_pc_i;
          cause_q <= cause_i;
          mode_q  <= miss_i ? MODE_REFILL : MODE_EXL;
        end
        MODE_EXL:    if (eret_i)        mode_q <= MODE_RUN;
        MODE_REFILL: if (refill_done_i) mode_q <= MODE_RUN;
        default:                        mode_q <= MODE_RUN;
      endcase
    end
  end

  assign mode_o  = mode_q;
  assign epc_o   = epc_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/excp_commit_ctrl.sv
module excp_commit_ctrl
  import excp_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter int              NSTG        = 5,
  parameter int              SQ_DEPTH    = 8,
  parameter int              INSTR_BYTES = 4,
  parameter logic [XLEN-1:0] HANDLER_PC  = 32'h0000_0180,
  localparam int             SQ_IW       = $clog2(SQ_DEPTH),
  localparam int             WB          = NSTG - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NSTG-1:0]    stg_vld_i,
  input  logic               wb_exc_i,
  input  logic [CAUSE_W-1:0] wb_cause_i,
  input  logic [XLEN-1:0]    wb_pc_i,
  input  logic               wb_dslot_i,
  input  logic               wb_rf_we_i,
  input  logic               wb_store_i,
  input  logic [SQ_IW-1:0]   wb_sq_idx_i,
  input  logic [XLEN-1:0]    ex_a_i,
  input  logic [XLEN-1:0]    ex_b_i,
  input  logic               ex_trap_add_i,
  input  logic               eret_i,
  input  logic               refill_done_i,
  output logic [XLEN-1:0]    ex_sum_o,
  output logic               ex_ovf_o,
  output logic [NSTG-1:0]    stg_vld_o,
  output logic               rf_we_o,
  output logic               sq_commit_o,
  output logic               sq_cancel_o,
  output logic [SQ_IW-1:0]   sq_idx_o,
  output logic               redirect_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               exl_o,
  output logic               refill_wait_o
);
  mode_e           mode;
  logic            take;
  logic            is_miss;
  logic            kill_all;
  logic [XLEN-1:0] restart_pc;

  excp_add_ovf #(.XLEN(XLEN)) u_add (
    .a_i    (ex_a_i),
    .b_i    (ex_b_i),
    .trap_i (ex_trap_add_i),
    .sum_o  (ex_sum_o),
    .ovf_o  (ex_ovf_o)
  );

  excp_restart_pc #(.XLEN(XLEN), .INSTR_BYTES(INSTR_BYTES)) u_rpc (
    .pc_i         (wb_pc_i),
    .dslot_i      (wb_dslot_i),
    .restart_pc_o (restart_pc)
  );

  // faults only count in run mode; in other modes they come from flushed work
  assign take    = stg_vld_i[WB] & wb_exc_i & (mode == MODE_RUN);
  assign is_miss = (wb_cause_i == CAUSE_MISS);

  excp_mode_fsm #(.XLEN(XLEN)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .take_i        (take),
    .miss_i        (is_miss),
    .eret_i        (eret_i),
    .refill_done_i (refill_done_i),
    .restart_pc_i  (restart_pc),
    .cause_i       (wb_cause_i),
    .mode_o        (mode),
    .epc_o         (epc_o),
    .cause_o       (cause_o)
  );

  assign kill_all = take | (mode == MODE_REFILL);

  excp_flush_gen #(.NSTG(NSTG)) u_flush (
    .vld_i  (stg_vld_i),
    .kill_i (kill_all),
    .vld_o  (stg_vld_o)
  );

  assign rf_we_o     = stg_vld_o[WB] & wb_rf_we_i;
  assign sq_commit_o = stg_vld_o[WB] & wb_store_i;
  assign sq_cancel_o = take & wb_store_i;
  assign sq_idx_o    = wb_sq_idx_i;

  assign exl_o         = (mode == MODE_EXL);
  assign refill_wait_o = (mode == MODE_REFILL);

  always_comb begin
    redirect_o    = 1'b0;
    redirect_pc_o = HANDLER_PC;
    if (take && !is_miss) begin
      redirect_o = 1'b1;
    end else if (exl_o && eret_i) begin
      redirect_o    = 1'b1;
      redirect_pc_o = epc_o;
    end else if (refill_wait_o && refill_done_i) begin
      redirect_o    = 1'b1;
      redirect_pc_o = epc_o;
    end
  end
endmodule

// File: rtl/excp_commit_ctrl_chk.sv
module excp_commit_ctrl_chk #(
  parameter int XLEN  = 32,
  parameter int NSTG  = 5,
  parameter int SQ_IW = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NSTG-1:0] stg_vld_i,
  input logic            wb_exc_i,
  input logic [3:0]      wb_cause_i,
  input logic [XLEN-1:0] wb_pc_i,
  input logic            wb_dslot_i,
  input logic            eret_i,
  input logic            refill_done_i,
  input logic            ex_trap_add_i,
  input logic            ex_ovf_o,
  input logic [NSTG-1:0] stg_vld_o,
  input logic            rf_we_o,
  input logic            sq_commit_o,
  input logic            sq_cancel_o,
  input logic            redirect_o,
  input logic [XLEN-1:0] redirect_pc_o,
  input logic [XLEN-1:0] epc_o,
  input logic [3:0]      cause_o,
  input logic            exl_o,
  input logic            refill_wait_o
);
  logic fault_now;
  assign fault_now = stg_vld_i[NSTG-1] && wb_exc_i && !exl_o && !refill_wait_o;

  AST_OVF_NEEDS_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_ovf_o |-> ex_trap_add_i); // R2
  AST_TAKE_FLUSHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_now |-> stg_vld_o == '0); // R3
  AST_TAKE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_now |-> !rf_we_o); // R4
  AST_SQ_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sq_cancel_o && sq_commit_o)); // R5
  AST_EXL_AFTER_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_now && wb_cause_i != 4'd3) |=> exl_o); // R6
  AST_EPC_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_now |=> epc_o == ($past(wb_dslot_i) ? $past(wb_pc_i) - 32'd4 : $past(wb_pc_i))); // R7
  AST_EXL_HOLDS_EPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exl_o |=> ($stable(epc_o) && $stable(cause_o))); // R8
  AST_ERET_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exl_o && eret_i) |-> (redirect_o && redirect_pc_o == epc_o)); // R9
  AST_REFILL_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_wait_o |-> (stg_vld_o == '0 && !rf_we_o)); // R10
  AST_MODES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exl_o && refill_wait_o)); // R10
  AST_REFILL_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_wait_o && refill_done_i) |=> !refill_wait_o); // R11
endmodule

bind excp_commit_ctrl excp_commit_ctrl_chk #(.XLEN(XLEN), .NSTG(NSTG), .SQ_IW(SQ_IW)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .stg_vld_i     (stg_vld_i),
  .wb_exc_i      (wb_exc_i),
  .wb_cause_i    (wb_cause_i),
  .wb_pc_i       (wb_pc_i),
  .wb_dslot_i    (wb_dslot_i),
  .eret_i        (eret_i),
  .refill_done_i (refill_done_i),
  .ex_trap_add_i (ex_trap_add_i),
  .ex_ovf_o      (ex_ovf_o),
  .stg_vld_o     (stg_vld_o),
  .rf_we_o       (rf_we_o),
  .sq_commit_o   (sq_commit_o),
  .sq_cancel_o   (sq_cancel_o),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o),
  .epc_o         (epc_o),
  .cause_o       (cause_o),
  .exl_o         (exl_o),
  .refill_wait_o (refill_wait_o)
);

// File: tb/excp_commit_ctrl_tb_top.sv
module excp_commit_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  stg_vld_i;
  logic        wb_exc_i;
  logic [3:0]  wb_cause_i;
  logic [31:0] wb_pc_i;
  logic        wb_dslot_i, wb_rf_we_i, wb_store_i;
  logic [2:0]  wb_sq_idx_i;
  logic [31:0] ex_a_i, ex_b_i;
  logic        ex_trap_add_i, eret_i, refill_done_i;
  logic [31:0] ex_sum_o;
  logic        ex_ovf_o;
  logic [4:0]  stg_vld_o;
  logic        rf_we_o, sq_commit_o, sq_cancel_o;
  logic [2:0]  sq_idx_o;
  logic        redirect_o;
  logic [31:0] redirect_pc_o, epc_o;
  logic [3:0]  cause_o;
  logic        exl_o, refill_wait_o;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;

  always #10 clk_i = ~clk_i;

  excp_commit_ctrl dut_i (.*);

  // {a, b, trap, expected sum, expected overflow}
  localparam logic [97:0] ADD_VEC [0:7] = '{
    {32'h0000_0001, 32'h0000_0002, 1'b1, 32'h0000_0003, 1'b0},
    {32'h7FFF_FFFF, 32'h0000_0001, 1'b1, 32'h8000_0000, 1'b1},
    {32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 32'h8000_0000, 1'b0},
    {32'h8000_0000, 32'h8000_0000, 1'b1, 32'h0000_0000, 1'b1},
    {32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 32'h7FFF_FFFF, 1'b1},
    {32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 32'h0000_0000, 1'b0},
    {32'hB2D0_5E00, 32'hB2D0_5E00, 1'b0, 32'h65A0_BC00, 1'b0},
    {32'hB2D0_5E00, 32'hB2D0_5E00, 1'b1, 32'h65A0_BC00, 1'b1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    stg_vld_i = '0; wb_exc_i = 0; wb_cause_i = '0; wb_pc_i = '0; wb_dslot_i = 0;
    wb_rf_we_i = 0; wb_store_i = 0; wb_sq_idx_i = '0; ex_a_i = '0; ex_b_i = '0;
    ex_trap_add_i = 0; eret_i = 0; refill_done_i = 0;
  endtask

  task automatic fault(input logic [3:0] c, input logic [31:0] pc, input logic ds);
    stg_vld_i = 5'h1F; wb_exc_i = 1; wb_cause_i = c; wb_pc_i = pc; wb_dslot_i = ds;
    wb_rf_we_i = 1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    quiet();
    #15;
    chk("R1 exl in reset", exl_o, 0);
    chk("R1 epc in reset", epc_o, 0);
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i); #5;
    chk("R1 exl", exl_o, 0);
    chk("R1 wait", refill_wait_o, 0);
    chk("R1 redirect", redirect_o, 0);
    chk("R1 epc", epc_o, 0);
    chk("R1 cause", cause_o, 0);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      {ex_a_i, ex_b_i, ex_trap_add_i} = ADD_VEC[i][97:33];
      #5;
      chk("R2 sum", ex_sum_o, ADD_VEC[i][32:1]);
      chk("R2 ovf", ex_ovf_o, ADD_VEC[i][0]);
    end

    // normal retire with store
    @(negedge clk_i); quiet();
    stg_vld_i = 5'h15; wb_rf_we_i = 1; wb_store_i = 1; wb_sq_idx_i = 3'd6; #5;
    chk("R3 pass-through", stg_vld_o, 5'h15);
    chk("R4 write", rf_we_o, 1);
    chk("R5 commit", sq_commit_o, 1);
    chk("R5 no cancel", sq_cancel_o, 0);
    chk("R5 idx", sq_idx_o, 6);

    @(negedge clk_i); quiet(); eret_i = 1; #5;
    chk("R9 idle eret", redirect_o, 0);
    @(negedge clk_i); quiet(); #5;
    chk("R9 idle eret mode", exl_o, 0);

    // overflow fault on a store
    @(negedge clk_i); quiet(); fault(4'd1, 32'h0000_1000, 0);
    wb_store_i = 1; wb_sq_idx_i = 3'd5; #5;
    chk("R3 flush", stg_vld_o, 5'h00);
    chk("R4 no write", rf_we_o, 0);
    chk("R5 cancel", sq_cancel_o, 1);
    chk("R5 cancel idx", sq_idx_o, 5);
    chk("R5 no commit", sq_commit_o, 0);
    chk("R6 redirect", redirect_o, 1);
    chk("R6 handler", redirect_pc_o, 32'h180);
    @(negedge clk_i); quiet(); #5;
    chk("R6 exl", exl_o, 1);
    chk("R7 epc", epc_o, 32'h1000);
    chk("R7 cause", cause_o, 1);

    // second fault during exl
    @(negedge clk_i); quiet(); fault(4'd2, 32'h0000_2000, 0); #5;
    chk("R8 no redirect", redirect_o, 0);
    chk("R8 valids kept", stg_vld_o, 5'h1F);
    @(negedge clk_i); quiet(); #5;
    chk("R8 epc kept", epc_o, 32'h1000);
    chk("R8 cause kept", cause_o, 1);

    eret_i = 1; #1;
    chk("R9 eret redirect", redirect_o, 1);
    chk("R9 eret target", redirect_pc_o, 32'h1000);
    @(negedge clk_i); quiet(); #5;
    chk("R9 exl clear", exl_o, 0);

    // delay-slot fault
    @(negedge clk_i); quiet(); fault(4'd2, 32'h0000_3008, 1); #5;
    chk("R6 slot redirect", redirect_o, 1);
    @(negedge clk_i); quiet(); #5;
    chk("R7 slot epc", epc_o, 32'h3004);
    chk("R7 slot cause", cause_o, 2);
    eret_i = 1; #1;
    chk("R9 slot target", redirect_pc_o, 32'h3004);
    @(negedge clk_i); quiet(); #5;

    // cache-miss restart
    @(negedge clk_i); quiet(); fault(4'd3, 32'h0000_4000, 0); #5;
    chk("R10 no redirect", redirect_o, 0);
    chk("R10 flush", stg_vld_o, 5'h00);
    @(negedge clk_i); quiet(); #5;
    chk("R10 wait", refill_wait_o, 1);
    chk("R10 no exl", exl_o, 0);
    chk("R7 miss cause", cause_o, 3);
    stg_vld_i = 5'h1F; wb_rf_we_i = 1; #1;
    chk("R10 held invalid", stg_vld_o, 5'h00);
    chk("R10 held no write", rf_we_o, 0);
    @(negedge clk_i); quiet(); fault(4'd1, 32'h0000_5000, 0); #5;
    chk("R10 fault ignored", redirect_o, 0);
    @(negedge clk_i); quiet(); #5;
    chk("R10 epc kept", epc_o, 32'h4000);
    refill_done_i = 1; #1;
    chk("R11 restart", redirect_o, 1);
    chk("R11 target", redirect_pc_o, 32'h4000);
    @(negedge clk_i); quiet(); #5;
    chk("R11 wait clear", refill_wait_o, 0);
    refill_done_i = 1; #1;
    chk("R11 idle done", redirect_o, 0);
    @(negedge clk_i); quiet(); #5;
    chk("R11 idle mode", refill_wait_o, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule